// File: doc/BRIEF.md
# General-Purpose I/O Port with Peripheral Override

This block controls an 8-pin bidirectional general-purpose I/O port. Software uses a small register bus to reach four registers: a port register, an output latch, a direction register and an analog-select register. Each pin is an input or an output according to its own direction bit. Pad cells, input buffers and peripheral logic sit outside the block. The block drives an output-enable and an output value for each pin, and it samples the pin input levels.

Peripherals can claim pins under a fixed priority: external memory address first, then PWM, then analog select, then the latch and direction bits. When the external memory interface is enabled, the low four pins carry address bits 16 to 19 and ignore the direction bits. The upper four pins can be driven by PWM channels. Each channel can be set to release its pin during a shutdown event. An upper pin marked analog has no driver and reads back as zero.

Top module: `gpio_ovr_port`

## Requirements
- R1: With no override active, a direction bit of 1 gives pin_oe_o=0 for that pin. A direction bit of 0 gives pin_oe_o=1 and pin_out_o equal to the latch bit.
- R2: A read at address 1 returns the stored latch value whatever the pin levels are. A write at address 1 updates the latch.
- R3: A write at address 0 updates the latch. A read at address 0 returns each pin level through a two-flop synchronizer: a pin change made between two clock edges shows up after the second rising edge, not after the first.
- R4: After reset the direction register (address 2) reads 0xFF, the latch reads 0x00 and the analog register (address 3) reads 0x0F. Every pin_oe_o is 0.
- R5: While xmem_en_i is 1, pins 0 to 3 have pin_oe_o=1 and pin_out_o equal to xmem_addr_i (bit 0 on pin 0). Direction and latch do not affect these pins.
- R6: On pin 4+k, with pwm_en_i[k]=1 the pin drives pwm_val_i[k] when its direction bit is 0 and no tri-state shutdown applies. With direction bit 1 it does not drive. PWM takes priority over the analog select and the latch.
- R7: When pwm_en_i[k], pwm_shdn_i[k] and pwm_tri_i[k] are all 1, pin 4+k has pin_oe_o=0. If pwm_tri_i[k] is 0, shutdown leaves the pin driving pwm_val_i[k].
- R8: An upper pin whose analog bit is 1 and which has no PWM enable has pin_oe_o=0. Its bit in the address 0 read is 0.
- R9: Address 3 bit k selects analog mode for pin 4+k. Bits 7:4 of an address 3 read are always 0.
- R10: A pin with pin_oe_o=0 has pin_out_o=0.
- R11: Writing 0xCF to the direction register with no overrides makes only pins 4 and 5 outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register select: 0 port, 1 latch, 2 direction, 3 analog |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for addr_i |
| pin_in_i | input | 8 | Pin input levels (asynchronous) |
| pin_oe_o | output | 8 | Per-pin output enable |
| pin_out_o | output | 8 | Per-pin output value |
| xmem_en_i | input | 1 | External memory interface enable |
| xmem_addr_i | input | 4 | Address bits 16 to 19 for pins 0 to 3 |
| pwm_en_i | input | 4 | PWM ownership of pins 4 to 7 |
| pwm_val_i | input | 4 | PWM output levels for pins 4 to 7 |
| pwm_shdn_i | input | 4 | PWM shutdown event per channel |
| pwm_tri_i | input | 4 | Release the pin during shutdown, per channel |

## Verification
The bench goes after the points where one override meets another. PWM on a pin whose direction bit is 1 must not drive; a design that ignored the direction bit would drive a pin that should be an input. The memory override must hold with direction 0xFF; a wrong design would leave the address pins floating. Shutdown with and without tri-state is tested on the same vector; swapping the two would release the wrong pins. Reads of the latch while the pins hold the opposite level catch a design that returns the pin level in place of the latch. Port reads are sampled one edge and two edges after a pin change, which catches a synchronizer with the wrong number of stages. Analog pins are checked to read as zero.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  typedef enum logic [1:0] {
    REG_PORT = 2'd0,
    REG_LAT  = 2'd1,
    REG_DIR  = 2'd2,
    REG_ANA  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs
  import gpio_ovr_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int NUM_UP   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          addr_i,
  input  logic                we_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] lat_q_o,
  output logic [NUM_PINS-1:0] dir_q_o,
  output logic [NUM_UP-1:0]   ana_q_o
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q_o <= '0;
      dir_q_o <= '1;
      ana_q_o <= '1;
    end else if (we_i) begin
      unique case (sel)
        REG_PORT, REG_LAT: lat_q_o <= wdata_i;
        REG_DIR:           dir_q_o <= wdata_i;
        REG_ANA:           ana_q_o <= wdata_i[NUM_UP-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[s] <= '0;
      else if (s == 0) chain[s] <= d_i;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/gpio_ovr_mux.sv
module gpio_ovr_mux #(
  parameter int NUM_PINS = 8,
  parameter int NUM_LO   = 4,
  localparam int NUM_UP  = NUM_PINS - NUM_LO
) (
  input  logic [NUM_PINS-1:0] lat_i,
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic [NUM_UP-1:0]   ana_i,
  input  logic                xmem_en_i,
  input  logic [NUM_LO-1:0]   xmem_addr_i,
  input  logic [NUM_UP-1:0]   pwm_en_i,
  input  logic [NUM_UP-1:0]   pwm_val_i,
  input  logic [NUM_UP-1:0]   pwm_shdn_i,
  input  logic [NUM_UP-1:0]   pwm_tri_i,
  output logic [NUM_PINS-1:0] oe_o,
  output logic [NUM_PINS-1:0] out_o
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic oe, val;
    if (i < NUM_LO) begin : g_lo
      always_comb begin
        if (xmem_en_i) begin
          oe  = 1'b1;
          val = xmem_addr_i[i];
        end else begin
          oe  = ~dir_i[i];
          val = lat_i[i];
        end
      end
    end else begin : g_up
      localparam int K = i - NUM_LO;
      always_comb begin
        oe  = 1'b0;
        val = 1'b0;
        if (pwm_en_i[K]) begin
          // direction still gates the PWM driver; shutdown may release it
          if (!dir_i[i] && !(pwm_shdn_i[K] && pwm_tri_i[K])) begin
            oe  = 1'b1;
            val = pwm_val_i[K];
          end
        end else if (!ana_i[K]) begin
          oe  = ~dir_i[i];
          val = lat_i[i];
        end
      end
    end
    assign oe_o[i]  = oe;
    assign out_o[i] = oe & val;
  end
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_ovr_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int NUM_LO      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_UP     = NUM_PINS - NUM_LO
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          addr_i,
  input  logic                we_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] pin_in_i,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic [NUM_PINS-1:0] pin_out_o,
  input  logic                xmem_en_i,
  input  logic [NUM_LO-1:0]   xmem_addr_i,
  input  logic [NUM_UP-1:0]   pwm_en_i,
  input  logic [NUM_UP-1:0]   pwm_val_i,
  input  logic [NUM_UP-1:0]   pwm_shdn_i,
  input  logic [NUM_UP-1:0]   pwm_tri_i
);
  logic [NUM_PINS-1:0] lat_q, dir_q, pin_sync;
  logic [NUM_UP-1:0]   ana_q;
  logic [NUM_PINS-1:0] ana_mask;

  gpio_ovr_regs #(.NUM_PINS(NUM_PINS), .NUM_UP(NUM_UP)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .we_i    (we_i),
    .wdata_i (wdata_i),
    .lat_q_o (lat_q),
    .dir_q_o (dir_q),
    .ana_q_o (ana_q)
  );

  gpio_ovr_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_in_i),
    .q_o    (pin_sync)
  );

  gpio_ovr_mux #(.NUM_PINS(NUM_PINS), .NUM_LO(NUM_LO)) u_mux (
    .lat_i       (lat_q),
    .dir_i       (dir_q),
    .ana_i       (ana_q),
    .xmem_en_i   (xmem_en_i),
    .xmem_addr_i (xmem_addr_i),
    .pwm_en_i    (pwm_en_i),
    .pwm_val_i   (pwm_val_i),
    .pwm_shdn_i  (pwm_shdn_i),
    .pwm_tri_i   (pwm_tri_i),
    .oe_o        (pin_oe_o),
    .out_o       (pin_out_o)
  );

  assign ana_mask = {ana_q, {NUM_LO{1'b0}}};

  always_comb begin
    unique case (reg_sel_e'(addr_i))
      REG_PORT: rdata_o = pin_sync & ~ana_mask;
      REG_LAT:  rdata_o = lat_q;
      REG_DIR:  rdata_o = dir_q;
      REG_ANA:  rdata_o = {{NUM_LO{1'b0}}, ana_q};
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_ovr_port_chk.sv
module gpio_ovr_port_chk #(
  parameter int NUM_PINS = 8,
  parameter int NUM_LO   = 4,
  localparam int NUM_UP  = NUM_PINS - NUM_LO
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [1:0]          addr_i,
  input logic                we_i,
  input logic [NUM_PINS-1:0] wdata_i,
  input logic [NUM_PINS-1:0] rdata_o,
  input logic [NUM_PINS-1:0] pin_oe_o,
  input logic [NUM_PINS-1:0] pin_out_o,
  input logic                xmem_en_i,
  input logic [NUM_LO-1:0]   xmem_addr_i,
  input logic [NUM_UP-1:0]   pwm_en_i,
  input logic [NUM_UP-1:0]   pwm_shdn_i,
  input logic [NUM_UP-1:0]   pwm_tri_i,
  input logic [NUM_UP-1:0]   ana_q
);
  AST_UNDRIVEN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_out_o & ~pin_oe_o) == '0); // R10

  AST_XMEM_OWNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xmem_en_i |-> (pin_oe_o[NUM_LO-1:0] == '1 && pin_out_o[NUM_LO-1:0] == xmem_addr_i)); // R5

  AST_DIR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd2) |=>
      (!xmem_en_i |-> pin_oe_o[NUM_LO-1:0] == ~$past(wdata_i[NUM_LO-1:0]))); // R1

  AST_LAT_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i[1] == 1'b0) |=>
      ((!we_i && addr_i == 2'd1) |-> rdata_o == $past(wdata_i))); // R2

  AST_ANA_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 2'd0) |-> (rdata_o[NUM_PINS-1:NUM_LO] & ana_q) == '0); // R8

  AST_ANA_HI_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 2'd3) |-> rdata_o[NUM_PINS-1:NUM_UP] == '0); // R9

  for (genvar k = 0; k < NUM_UP; k++) begin : g_up
    AST_PWM_TRISTATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pwm_en_i[k] && pwm_shdn_i[k] && pwm_tri_i[k]) |-> !pin_oe_o[NUM_LO+k]); // R7
  end
endmodule

bind gpio_ovr_port gpio_ovr_port_chk #(.NUM_PINS(NUM_PINS), .NUM_LO(NUM_LO)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .we_i        (we_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .pin_oe_o    (pin_oe_o),
  .pin_out_o   (pin_out_o),
  .xmem_en_i   (xmem_en_i),
  .xmem_addr_i (xmem_addr_i),
  .pwm_en_i    (pwm_en_i),
  .pwm_shdn_i  (pwm_shdn_i),
  .pwm_tri_i   (pwm_tri_i),
  .ana_q       (ana_q)
);

// File: tb/gpio_ovr_port_test.sv
module gpio_ovr_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;

  typedef struct packed {
    logic [7:0] dir;
    logic [7:0] lat;
    logic [3:0] ana;
    logic       xen;
    logic [3:0] xa;
    logic [3:0] pen;
    logic [3:0] pval;
    logic [3:0] pshd;
    logic [3:0] ptri;
    logic [7:0] eoe;
    logic [7:0] eout;
  } vec_t;

  // dir lat ana xen xa pen pval pshd ptri | exp_oe exp_out
  localparam vec_t VECS [NV] = '{
    '{8'hFF, 8'hA5, 4'h0, 1'b0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 8'h00, 8'h00}, // R1 R10
    '{8'h00, 8'hA5, 4'h0, 1'b0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 8'hFF, 8'hA5}, // R1
    '{8'hCF, 8'hFF, 4'h0, 1'b0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 8'h30, 8'h30}, // R11
    '{8'h00, 8'h00, 4'h0, 1'b1, 4'hA, 4'h0, 4'h0, 4'h0, 4'h0, 8'hFF, 8'h0A}, // R5
    '{8'hFF, 8'h00, 4'hF, 1'b1, 4'h5, 4'h0, 4'h0, 4'h0, 4'h0, 8'h0F, 8'h05}, // R5 R8
    '{8'h00, 8'hFF, 4'hF, 1'b0, 4'h0, 4'hF, 4'h5, 4'h0, 4'h0, 8'hFF, 8'h5F}, // R6
    '{8'h00, 8'h00, 4'h0, 1'b0, 4'h0, 4'hF, 4'hF, 4'hF, 4'h3, 8'hCF, 8'hC0}, // R7
    '{8'h50, 8'hFF, 4'h0, 1'b0, 4'h0, 4'h3, 4'h0, 4'h0, 4'h0, 8'hAF, 8'h8F}, // R6
    '{8'h00, 8'hF0, 4'h5, 1'b0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 8'hAF, 8'hA0}  // R8
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_oe, pin_out;
  logic       xmem_en = 1'b0;
  logic [3:0] xmem_addr = '0;
  logic [3:0] pwm_en = '0, pwm_val = '0, pwm_shdn = '0, pwm_tri = '0;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_ovr_port uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_in_i(pin_in), .pin_oe_o(pin_oe), .pin_out_o(pin_out),
    .xmem_en_i(xmem_en), .xmem_addr_i(xmem_addr), .pwm_en_i(pwm_en),
    .pwm_val_i(pwm_val), .pwm_shdn_i(pwm_shdn), .pwm_tri_i(pwm_tri)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_check(string req, logic [1:0] a, logic [7:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R4 reset state
    #1;
    check("R4 oe", pin_oe, 8'h00);
    rd_check("R4 dir", 2'd2, 8'hFF);
    rd_check("R4 lat", 2'd1, 8'h00);
    rd_check("R4 ana", 2'd3, 8'h0F);

    // vector table: R1 R5 R6 R7 R8 R10 R11
    for (int i = 0; i < NV; i++) begin
      wr(2'd2, VECS[i].dir);
      wr(2'd1, VECS[i].lat);
      wr(2'd3, {4'h0, VECS[i].ana});
      @(negedge clk);
      xmem_en = VECS[i].xen; xmem_addr = VECS[i].xa;
      pwm_en = VECS[i].pen; pwm_val = VECS[i].pval;
      pwm_shdn = VECS[i].pshd; pwm_tri = VECS[i].ptri;
      #1;
      check($sformatf("vec%0d oe R1/R5/R6/R7/R8/R11", i), pin_oe, VECS[i].eoe);
      check($sformatf("vec%0d out R10", i), pin_out, VECS[i].eout);
    end
    @(negedge clk);
    xmem_en = 0; pwm_en = '0; pwm_shdn = '0; pwm_tri = '0;

    // R3 port write lands in latch; R2 latch read ignores pin levels
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h3C);
    @(negedge clk);
    pin_in = 8'hC3;
    addr = 2'd0;
    @(posedge clk); #1;
    check("R3 sync one edge", rdata, 8'h00);
    @(posedge clk); #1;
    check("R3 sync two edges", rdata, 8'hC3);
    rd_check("R2 latch read", 2'd1, 8'h3C);
    wr(2'd1, 8'h81);
    rd_check("R2 latch write", 2'd1, 8'h81);

    // R8 analog pins read zero
    wr(2'd3, 8'h0C);
    rd_check("R8 analog read", 2'd0, 8'h03);
    // R9 upper bits of analog register
    wr(2'd3, 8'hFF);
    rd_check("R9 ana readback", 2'd3, 8'h0F);

    // R11 0xCF with upper pins digital
    wr(2'd3, 8'h00);
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'hCF);
    @(negedge clk); #1;
    check("R11 dir CF", pin_oe, 8'h30);

    // R4 reset again from a modified state
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R4 oe in reset", pin_oe, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    rd_check("R4 dir after reset", 2'd2, 8'hFF);
    rd_check("R4 ana after reset", 2'd3, 8'h0F);
    finish_run();
  end
endmodule